// File: doc/BRIEF.md
# Excluding Random Tag Generator

The block produces a 4-bit allocation tag for tagged-memory pointers. A request either asks for a fresh pseudo-random tag or asks for a tag derived from the one already held in a pointer. In both cases a step count is found first. The block then starts from a start tag and moves forward through the 16 tag values, modulo 16, skipping every value whose bit is set in a 16-bit exclusion mask. It examines one candidate per clock cycle.

In random mode the start tag and a 16-bit seed come from a 24-bit state register. Four steps of a 16-bit shift register on that seed give the step count. When the generation finishes, the state register is rewritten. In tag-adjust mode the start tag is taken from pointer bits [59:56] and the step count from a 4-bit immediate. The chosen tag is placed back into bits [59:56] of the pointer. A stored seed of zero with the reseed-enable bit set makes the block fetch a non-zero seed from an entropy input first.

Top module: `tag_gen`

## Requirements
- R1: One shift step on seed s computes b = s[5]^s[3]^s[2]^s[0] and gives {b, s[15:1]}. A random generation takes four steps, and the bit from step i (i = 0..3) becomes bit i of the step count.
- R2: In random mode (`mode_rand`=1) the exclusion mask is `op_excl | ctl_excl`, and the start tag is state bits [3:0]. The seed is state bits [23:8].
- R3: In tag-adjust mode (`mode_rand`=0) only `ctl_excl` excludes. The start tag is `ptr_in[59:56]` and the step count is `imm`.
- R4: If all 16 exclusion bits are set, the result tag is 0.
- R5: With step count 0, the result is the start tag when that tag is not excluded. Otherwise it is the first non-excluded tag found by counting upward modulo 16.
- R6: With step count N>0, the block moves upward modulo 16 to the next non-excluded tag, N times in a row. The start tag itself is not counted.
- R7: After a random generation, the state register reads {updated seed, 4'b0, result tag}, with the seed in bits [23:8]. A tag-adjust request leaves the state register unchanged.
- R8: If the stored seed is 0 and `ctl_rrnd`=1 in random mode, the block waits until `ent_valid` brings a non-zero `ent_data` and uses that value as the seed. A zero entropy value is retried.
- R9: While the block is waiting for a reseed, `ent_fail`=1 makes the seed 1.
- R10: `res_ptr` equals the accepted pointer with bits [59:56] replaced by `res_tag`. All other bits are unchanged.
- R11: `done` is high for exactly one cycle per accepted request. `busy` is high from acceptance until that cycle. A `req` seen while `busy` is high is ignored.
- R12: After reset, `st_rd` is 0 and the outputs are 0. A write through `st_we`/`st_wd` appears on `st_rd` on the next cycle, unless a random generation finishes in the same cycle, in which case the generation's update takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a generation (accepted when not busy) |
| mode_rand | input | 1 | 1 = random mode, 0 = tag-adjust mode |
| ptr_in | input | 64 | Pointer to receive the tag |
| imm | input | 4 | Step count for tag-adjust mode |
| op_excl | input | 16 | Operand exclusion mask (random mode only) |
| ctl_excl | input | 16 | Control exclusion mask |
| ctl_rrnd | input | 1 | Allow reseed from entropy when the seed is zero |
| st_we | input | 1 | State register write enable |
| st_wd | input | 24 | State register write data |
| st_rd | output | 24 | State register contents |
| ent_valid | input | 1 | Entropy word valid |
| ent_data | input | 16 | Entropy word |
| ent_fail | input | 1 | Entropy source failure |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| res_tag | output | 4 | Chosen tag |
| res_ptr | output | 64 | Pointer carrying the chosen tag |

## Verification
A corrupted shift step or a wrong step count shows up at once in the `done` cycle, as the wrong `res_tag` and the wrong seed on `st_rd`. Every later random result then drifts from the reference sequence as well. A skip walk that ignores an exclusion bit, or that mishandles the wrap from 15 to 0, gives a tag whose mask bit is set, or gives the wrong neighbour. A control state stuck in the reseed wait or in the walk appears as `done` never rising, or as a second `done`. The bench therefore compares tag, pointer and state after every request, and watches for stray strobes.

// File: rtl/tag_gen.sv
module tag_gen #(
  parameter int TAG_LSB = 56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        mode_rand,
  input  logic [63:0] ptr_in,
  input  logic [3:0]  imm,
  input  logic [15:0] op_excl,
  input  logic [15:0] ctl_excl,
  input  logic        ctl_rrnd,
  input  logic        st_we,
  input  logic [23:0] st_wd,
  output logic [23:0] st_rd,
  input  logic        ent_valid,
  input  logic [15:0] ent_data,
  input  logic        ent_fail,
  output logic        busy,
  output logic        done,
  output logic [3:0]  res_tag,
  output logic [63:0] res_ptr
);
  typedef enum logic [1:0] {S_IDLE, S_SEED, S_WALK} st_e;

  st_e         state;
  logic [23:0] st_q;
  logic [15:0] excl_q, seed_q;
  logic [63:0] ptr_q;
  logic [3:0]  cand, left;
  logic        chk_cur, mode_q, rrnd_q, done_q;
  logic [3:0]  tag_q;

  function automatic logic [19:0] step4(input logic [15:0] s);
    logic [15:0] v;
    logic [3:0]  o;
    logic        b;
    v = s;
    o = '0;
    for (int i = 0; i < 4; i++) begin
      b    = v[5] ^ v[3] ^ v[2] ^ v[0];
      v    = {b, v[15:1]};
      o[i] = b;
    end
    return {v, o};
  endfunction

  logic [15:0] ent_pick, step_src;
  logic [19:0] step_res;
  logic        ent_ok, seed_zero;

  assign ent_ok    = ent_fail || (ent_valid && ent_data != 16'd0);
  assign ent_pick  = ent_fail ? 16'd1 : ent_data;
  assign step_src  = (state == S_SEED) ? ent_pick : st_q[23:8];
  assign step_res  = step4(step_src);
  assign seed_zero = (st_q[23:8] == 16'd0);

  logic       allx, fin, fin_rand;
  logic [3:0] nxt, fin_tag;

  assign allx    = &excl_q;
  assign nxt     = cand + 4'd1;
  assign fin     = (state == S_WALK) &&
                   (allx || (chk_cur ? !excl_q[cand] : (!excl_q[nxt] && left == 4'd1)));
  assign fin_tag = allx ? 4'd0 : (chk_cur ? cand : nxt);
  assign fin_rand = fin && mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      st_q    <= '0;
      excl_q  <= '0;
      seed_q  <= '0;
      ptr_q   <= '0;
      cand    <= '0;
      left    <= '0;
      chk_cur <= 1'b0;
      mode_q  <= 1'b0;
      rrnd_q  <= 1'b0;
      done_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (fin_rand)
        st_q <= {seed_q, 4'd0, fin_tag};
      else if (st_we)
        st_q <= st_wd;
      case (state)
        S_IDLE: if (req) begin
          mode_q <= mode_rand;
          rrnd_q <= ctl_rrnd;
          ptr_q  <= ptr_in;
          if (mode_rand) begin
            excl_q <= op_excl | ctl_excl;
            cand   <= st_q[3:0];
            if (seed_zero && ctl_rrnd) begin
              state <= S_SEED;
            end else begin
              seed_q  <= step_res[19:4];
              left    <= step_res[3:0];
              chk_cur <= (step_res[3:0] == 4'd0);
              state   <= S_WALK;
            end
          end else begin
            excl_q  <= ctl_excl;
            cand    <= ptr_in[TAG_LSB+3:TAG_LSB];
            left    <= imm;
            chk_cur <= (imm == 4'd0);
            state   <= S_WALK;
          end
        end
        S_SEED: if (ent_ok) begin
          seed_q  <= step_res[19:4];
          left    <= step_res[3:0];
          chk_cur <= (step_res[3:0] == 4'd0);
          state   <= S_WALK;
        end
        S_WALK: begin
          if (fin) begin
            tag_q  <= fin_tag;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (chk_cur) begin
            cand <= nxt;
          end else begin
            cand <= nxt;
            if (!excl_q[nxt]) left <= left - 4'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign st_rd   = st_q;
  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign res_tag = tag_q;

  always_comb begin
    res_ptr = ptr_q;
    res_ptr[TAG_LSB+3:TAG_LSB] = tag_q;
  end
endmodule

// File: rtl/tag_gen_chk.sv
module tag_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        busy,
  input logic [3:0]  res_tag,
  input logic [63:0] res_ptr,
  input logic [63:0] ptr_q,
  input logic [15:0] excl_q,
  input logic        st_we,
  input logic [23:0] st_wd,
  input logic [23:0] st_rd,
  input logic        fin_rand,
  input logic        mode_q,
  input logic        rrnd_q
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_ALL_EXCL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && excl_q == 16'hffff) |-> res_tag == 4'd0); // R4
  AST_TAG_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && excl_q != 16'hffff) |-> !excl_q[res_tag]); // R5
  AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_ptr[63:60] == ptr_q[63:60] && res_ptr[55:0] == ptr_q[55:0]
              && res_ptr[59:56] == res_tag)); // R10
  AST_STATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !fin_rand) |=> st_rd == $past(st_wd)); // R12
  AST_STATE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> st_rd[3:0] == res_tag); // R7
  AST_RESEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q && rrnd_q) |-> st_rd[23:8] != 16'd0); // R8
endmodule

bind tag_gen tag_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .res_tag(res_tag),
  .res_ptr(res_ptr), .ptr_q(ptr_q), .excl_q(excl_q), .st_we(st_we),
  .st_wd(st_wd), .st_rd(st_rd), .fin_rand(fin_rand), .mode_q(mode_q),
  .rrnd_q(rrnd_q)
);

// File: tb/test_tag_gen.sv
module test_tag_gen;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, mode_rand = 0, ctl_rrnd = 0, st_we = 0;
  logic        ent_valid = 0, ent_fail = 0;
  logic [63:0] ptr_in = '0;
  logic [3:0]  imm = '0;
  logic [15:0] op_excl = '0, ctl_excl = '0, ent_data = '0;
  logic [23:0] st_wd = '0;
  logic [23:0] st_rd;
  logic        busy, done;
  logic [3:0]  res_tag;
  logic [63:0] res_ptr;

  int n_chk = 0, n_bad = 0;
  logic [23:0] st_m = '0;

  always #2 clk = ~clk;

  tag_gen i_tag_gen (.*);

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [19:0] m_step(input logic [15:0] s);
    logic [15:0] v = s; logic [3:0] o = 0; logic b;
    for (int i = 0; i < 4; i++) begin
      b = v[5] ^ v[3] ^ v[2] ^ v[0];
      v = {b, v[15:1]}; o[i] = b;
    end
    return {v, o};
  endfunction

  function automatic logic [3:0] m_choose(input logic [3:0] t0, input logic [3:0] off,
                                          input logic [15:0] ex);
    logic [3:0] t = t0;
    if (ex == 16'hffff) return 0;
    if (off == 0) begin
      while (ex[t]) t = t + 1;
    end else begin
      for (int k = 0; k < off; k++) begin
        t = t + 1;
        while (ex[t]) t = t + 1;
      end
    end
    return t;
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic pulse_req();
    req = 1; @(negedge clk); req = 0;
  endtask

  task automatic run_adj(input string r, input logic [63:0] p, input logic [3:0] im,
                         input logic [15:0] ce, input logic [15:0] oe);
    bit ok; logic [3:0] et; logic [63:0] ep;
    mode_rand = 0; ptr_in = p; imm = im; ctl_excl = ce; op_excl = oe;
    et = m_choose(p[59:56], im, ce);
    ep = p; ep[59:56] = et;
    pulse_req();
    wait_done(ok);
    chk({r, " done"}, ok, 1);
    chk({r, " tag"}, res_tag, et);
    chk({r, " R10 ptr"}, res_ptr, ep);
    chk({r, " R7 state kept"}, st_rd, st_m);
  endtask

  task automatic run_rand(input string r, input logic [63:0] p, input logic [15:0] oe,
                          input logic [15:0] ce, input logic rr, input logic [15:0] ent);
    bit ok; logic [15:0] sd; logic [19:0] sr; logic [3:0] et; logic [63:0] ep;
    mode_rand = 1; ptr_in = p; op_excl = oe; ctl_excl = ce; ctl_rrnd = rr;
    sd = st_m[23:8];
    if (sd == 0 && rr) sd = ent;
    sr = m_step(sd);
    et = m_choose(st_m[3:0], sr[3:0], oe | ce);
    ep = p; ep[59:56] = et;
    pulse_req();
    wait_done(ok);
    st_m = {sr[19:4], 4'd0, et};
    chk({r, " done"}, ok, 1);
    chk({r, " R1 R2 tag"}, res_tag, et);
    chk({r, " R10 ptr"}, res_ptr, ep);
    chk({r, " R7 state"}, st_rd, st_m);
  endtask

  task automatic wr_state(input logic [23:0] v);
    st_we = 1; st_wd = v; @(negedge clk); st_we = 0;
    st_m = v;
    chk("R12 state write", st_rd, v);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk("R12 reset st_rd", st_rd, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset tag", res_tag, 0);
    rst_n = 1;
    @(negedge clk);

    run_adj("R5 off0 free", 64'h1234_5678_9abc_def0 | (64'h7 << 56), 0, 16'h0000, 16'h0);
    run_adj("R5 off0 skip wrap", 64'h0f00_0000_0000_0001, 0, 16'h8003, 16'h0);
    run_adj("R6 offN skip", 64'h0300_0000_0000_00aa, 3, 16'h0050, 16'h0);
    run_adj("R6 offN wrap", 64'hfe00_0000_0000_0000, 5, 16'h4001, 16'h0);
    run_adj("R3 op mask ignored", 64'h0200_0000_0000_0000, 1, 16'h0000, 16'hffff);
    run_adj("R4 all excl adj", 64'hffff_ffff_ffff_ffff, 7, 16'hffff, 16'h0);

    wr_state({16'hACE1, 4'h0, 4'h5});
    run_rand("R1 rand seeded", 64'h00aa_0000_0000_1234, 16'h0000, 16'h0000, 0, 0);
    run_rand("R2 rand or-mask", 64'h0, 16'h00f0, 16'h0f00, 0, 0);
    run_rand("R4 rand all excl", 64'h0, 16'hff00, 16'h00ff, 0, 0);

    wr_state(24'h000003);
    run_rand("R1 zero seed no rrnd", 64'h1, 16'h0008, 16'h0, 0, 0);

    // R8: zero entropy retried, busy held, extra req ignored (R11)
    wr_state(24'h00000a);
    ent_valid = 1; ent_data = 16'h0000;
    begin
      logic [19:0] sr; logic [3:0] et;
      mode_rand = 1; op_excl = 16'h0002; ctl_excl = 0; ctl_rrnd = 1; ptr_in = 64'h55;
      pulse_req();
      repeat (4) @(negedge clk);
      chk("R8 busy while entropy zero", busy, 1);
      chk("R8 no done while entropy zero", done, 0);
      mode_rand = 0; imm = 4'd9; ptr_in = 64'hffff;
      pulse_req();
      ent_data = 16'h1d2b;
      sr = m_step(16'h1d2b);
      et = m_choose(4'ha, sr[3:0], 16'h0002);
      wait_done(ok);
      st_m = {sr[19:4], 4'd0, et};
      chk("R8 done", ok, 1);
      chk("R8 tag", res_tag, et);
      chk("R8 state seed", st_rd, st_m);
      chk("R11 busy-time req ignored ptr", res_ptr, {8'h00 | {4'h0, et}, 56'h55});
      repeat (6) @(negedge clk);
      chk("R11 no second done", done, 0);
      chk("R11 idle", busy, 0);
    end
    ent_valid = 0;

    // R9: entropy failure
    wr_state(24'h000004);
    ent_fail = 1;
    run_rand("R9 fail seed 1", 64'h0, 16'h0, 16'h0, 1, 16'h0001);
    ent_fail = 0;

    // random mix
    ent_valid = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] p; logic [15:0] a, b, e;
      p = {$urandom, $urandom};
      a = $urandom; b = $urandom;
      if ($urandom_range(3) == 0) a = 0;
      if ($urandom_range(3) == 0) b = 0;
      e = $urandom | 1;
      ent_data = e;
      if ($urandom_range(9) == 0) wr_state({$urandom_range(1) ? 16'h0 : 16'($urandom), 8'($urandom)});
      if ($urandom_range(1)) run_rand("R1 R6 rnd", p, a, b, 1'($urandom), e);
      else run_adj("R3 R6 rnd", p, 4'($urandom), b, a);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed);
  end
endmodule